// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-driven master for the two-wire PHY management bus (IEEE 802.3 Clause 22). Software sees two 32-bit registers. The control register holds the MDC divisor and a preamble switch, and it shows a read-only busy flag. The data register takes one packed command word whose bit layout is the serial frame itself. One write to the data register sends one whole management transaction on MDC and MDIO.

The word is shifted out MSB first. Bits [31:30] are the start pattern, [29:28] the opcode, [27:23] the PHY address, [22:18] the register address, [17:16] the turnaround and [15:0] the data. If preamble is enabled, thirty-two ones go out before the word. In a read, the master releases MDIO from the turnaround onward and collects sixteen bits from the PHY. Software reads them back from the data register once busy has cleared. For a normal start-up, software writes divisor 0x1a with preamble on.

Top module: `mdio_master`

## Requirements
- R1: After reset the control register reads 0 (divisor 0, preamble off, busy clear), MDC is low and the MDIO output enable is low.
- R2: The control register at offset 0x0 holds the divisor in bits [6:0] and preamble-enable in bit 7, and it reads these back as written. Bit 8 is the busy flag and software writes to it have no effect.
- R3: A write to the data register (offset 0x4) while idle starts a transaction, and busy reads 1 in the cycle after the write.
- R4: While busy, MDC toggles every divisor+1 clock cycles, so consecutive rising edges are 2*(divisor+1) cycles apart. While idle, MDC stays low.
- R5: With preamble enabled, the frame has 64 MDC periods and the first 32 carry driven ones. With preamble disabled, it has 32 MDC periods and starts at the start bits.
- R6: Frame bits are word bits 31 down to 0, one per MDC period. Each bit changes after a falling MDC edge and is stable at the rising edge.
- R7: Opcode 2'b10 in bits [29:28] is a read. The output enable is low from frame bit 14 (turnaround) onward. MDIO input is sampled on the rising edges of the last 16 bits, and the sampled value is returned MSB first in data-register bits [15:0] after busy clears.
- R8: Any other opcode (1 = write) drives the output enable for all frame bits, including the turnaround and the data taken from the word.
- R9: Busy clears on the falling MDC edge that ends the last bit, which is divisor+1 cycles after the last rising MDC edge. Once busy is clear, MDC and the output enable are low.
- R10: A data-register write while busy is ignored, and the running frame continues unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register byte offset (0x0 control, 0x4 data) |
| bus_wr | input | 1 | Register write strobe, one cycle |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven when enabled |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value sampled from the line |

## Verification
Each transaction is replayed against a bench-side PHY that records the output and enable on every rising MDC edge. Write and read opcodes are mixed with preamble on and off and with divisors 0, 1, 2, 3 and 26. This tells apart errors in bit order, preamble length, turnaround release and MDC period. The returned read values (0xA5C3, 0x8001, 0x0000, 0x5A5A) expose shift-direction and end-bit faults, and they show that a zero read replaces earlier data. A command injected in the middle of a frame tests whether a busy master ignores new writes.

// File: rtl/mdio_pkg.sv
// Package: shared constants for the MDIO master.
// Assumes a 32-bit register bus and a Clause 22 frame of 32 bits.
package mdio_pkg;
    localparam int REG_W     = 32;
    localparam int FRAME_W   = 32;
    localparam int PRE_LEN   = 32;
    localparam int DATA_W    = 16;
    // field positions inside the command word; the word is the frame, MSB first
    localparam int OP_LSB    = 28;
    localparam int TA_LSB    = 16;
    // control register bits
    localparam int PRE_BIT   = 7;
    localparam int BUSY_BIT  = 8;
    // register offsets
    localparam int CTRL_OFS  = 0;
    localparam int DATA_OFS  = 4;
    localparam logic [1:0] OP_READ = 2'b10;
    // frame slot where the turnaround begins, and first data slot
    localparam int TA_SLOT   = FRAME_W - 2 - TA_LSB;
    localparam int DATA_SLOT = FRAME_W - DATA_W;
endpackage

// File: rtl/mdio_mdc_gen.sv
// Module: MDC generator. While en is high, MDC toggles every div+1 cycles,
// and one-cycle ticks flag the cycle right before each rising or falling edge.
// Assumes en drops in the same cycle as the final falling tick.
module mdio_mdc_gen #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [DIV_W-1:0] cnt;
    logic             mdc_q;
    logic             wrap;

    assign wrap      = en && (cnt == div);
    assign rise_tick = wrap && !mdc_q;
    assign fall_tick = wrap && mdc_q;
    assign mdc       = mdc_q;

    // half-period counter and MDC toggle; held low and cleared when idle
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt   <= '0;
            mdc_q <= 1'b0;
        end else if (wrap) begin
            cnt   <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_seq.sv
// Module: frame sequencer. It latches a command word at launch, sends the
// optional preamble and then the word MSB first, one bit per MDC period,
// and collects the read data. Assumes fall_tick/rise_tick come from MDC.
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  logic [FRAME_W-1:0] cmd_in,
    input  logic               pre_en,
    input  logic               rise_tick,
    input  logic               fall_tick,
    input  logic               mdio_i,
    output logic               busy,
    output logic               mdio_o,
    output logic               mdio_oe,
    output logic [DATA_W-1:0]  rd_data
);
    localparam int SLOT_W = $clog2(FRAME_W + PRE_LEN + 1);
    localparam int BIT_W  = $clog2(FRAME_W);

    logic               busy_q;
    logic               pre_q;
    logic [SLOT_W-1:0]  slot;
    logic [FRAME_W-1:0] cmd_q;
    logic [DATA_W-1:0]  rd_q;
    logic [SLOT_W-1:0]  off;
    logic [SLOT_W-1:0]  last;
    logic [SLOT_W-1:0]  fidx;
    logic [BIT_W-1:0]   bpos;
    logic               in_pre;
    logic               is_read;

    assign off     = pre_q ? SLOT_W'(PRE_LEN) : '0;
    assign last    = off + SLOT_W'(FRAME_W - 1);
    assign in_pre  = slot < off;
    assign fidx    = slot - off;
    assign bpos    = BIT_W'(FRAME_W - 1) - fidx[BIT_W-1:0];
    assign is_read = (cmd_q[OP_LSB+1:OP_LSB] == OP_READ);

    // line drive: ones in the preamble, then the word; released for read data
    assign mdio_o  = !busy_q || in_pre || cmd_q[bpos];
    assign mdio_oe = busy_q && (in_pre || !is_read || fidx < SLOT_W'(TA_SLOT));
    assign busy    = busy_q;
    assign rd_data = rd_q;

    // launch, slot advance on each falling MDC edge, and finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            pre_q  <= 1'b0;
            slot   <= '0;
            cmd_q  <= '0;
        end else if (launch && !busy_q) begin
            busy_q <= 1'b1;
            pre_q  <= pre_en;
            slot   <= '0;
            cmd_q  <= cmd_in;
        end else if (busy_q && fall_tick) begin
            if (slot == last) begin
                busy_q <= 1'b0;
                slot   <= '0;
            end else begin
                slot   <= slot + 1'b1;
            end
        end
    end

    // read data capture on rising MDC edges of the data slots
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (busy_q && rise_tick && is_read && !in_pre
                     && fidx >= SLOT_W'(DATA_SLOT)) begin
            rd_q <= {rd_q[DATA_W-2:0], mdio_i};
        end
    end

    // R6: the slot only moves on a falling MDC edge
    p_slot_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q) && slot != $past(slot)) |-> $past(fall_tick));

    // R10: a launch while busy leaves the running command untouched
    p_ignore_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && busy_q) |=> $stable(cmd_q));
endmodule

// File: rtl/mdio_master.sv
// Module: MDIO master top. It holds the control and data registers, decodes
// bus writes, and connects the MDC generator to the frame sequencer.
// Assumes single-cycle write strobes and a combinational read port.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DIV_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic [DIV_W-1:0]  div_q;
    logic              pre_en_q;
    logic              busy;
    logic              rise_tick;
    logic              fall_tick;
    logic              wr_ctrl;
    logic              wr_data;
    logic [DATA_W-1:0] rd_data;

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(CTRL_OFS));
    assign wr_data = bus_wr && (bus_addr == ADDR_W'(DATA_OFS));

    // control register: divisor and preamble switch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q    <= '0;
            pre_en_q <= 1'b0;
        end else if (wr_ctrl) begin
            div_q    <= bus_wdata[DIV_W-1:0];
            pre_en_q <= bus_wdata[PRE_BIT];
        end
    end

    // register read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(CTRL_OFS)) begin
            bus_rdata[DIV_W-1:0] = div_q;
            bus_rdata[PRE_BIT]   = pre_en_q;
            bus_rdata[BUSY_BIT]  = busy;
        end else if (bus_addr == ADDR_W'(DATA_OFS)) begin
            bus_rdata[DATA_W-1:0] = rd_data;
        end
    end

    mdio_mdc_gen #(.DIV_W(DIV_W)) clkgen_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (busy),
        .div       (div_q),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_seq seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (wr_data),
        .cmd_in    (bus_wdata),
        .pre_en    (pre_en_q),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .rd_data   (rd_data)
    );

    // R3: an idle data write raises busy on the next cycle
    p_busy_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && !busy) |=> busy);

    // R4: MDC is held low whenever the master is idle
    p_mdc_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !mdc);

    // R9: busy ends together with a falling MDC edge
    p_busy_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (!mdc && $past(mdc)));
endmodule

// File: tb/mdio_master_tb_top.sv
// Bench: a vector table of transactions replayed against a bench-side PHY,
// then directed tests for reset, register fields and ignored writes.
module mdio_master_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;
    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;

    mdio_master dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] phy,
                                       input logic [4:0] ra, input logic [15:0] d);
        return {2'b01, op, phy, ra, 2'b10, d};
    endfunction

    localparam int NV = 5;
    localparam logic [31:0] V_WORD [NV] = '{
        mk(2'b01, 5'd1,  5'd0,  16'h1234), mk(2'b10, 5'd5,  5'd2,  16'h0000),
        mk(2'b10, 5'd31, 5'd31, 16'h0000), mk(2'b01, 5'd15, 5'd10, 16'hFFFF),
        mk(2'b10, 5'd0,  5'd1,  16'h0000)};
    localparam logic        V_PRE [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
    localparam int          V_DIV [NV] = '{2, 0, 26, 1, 3};
    localparam logic [15:0] V_RD  [NV] = '{16'h0000, 16'hA5C3, 16'h8001, 16'hBEEF, 16'h0000};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // one full transaction with per-bit checking; inject=1 writes a second command mid-frame
    task automatic run_txn(input logic [31:0] word, input logic pre, input int div,
                           input logic [15:0] rdval, input bit inject);
        bit   isrd = (word[29:28] == 2'b10);
        int   off = pre ? 32 : 0;
        int   nrise = 0;
        int   t_last = 0;
        logic prev_mdc = 1'b0;
        bit   injected = 0;
        @(negedge clk);
        bus_addr = 3'd0; bus_wdata = 32'(div) | (32'(pre) << 7); bus_wr = 1'b1;
        @(negedge clk);
        bus_addr = 3'd4; bus_wdata = word; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 3'd0; #1;
        chk("R3 busy after data write", 32'(bus_rdata[8]), 32'd1);
        forever begin
            bus_wr = 1'b0; bus_addr = 3'd0; #1;
            if (!bus_rdata[8]) break;
            if (mdc && !prev_mdc) begin
                int  f = nrise - off;
                bit  exp_oe = (nrise < off) ? 1'b1 : !(isrd && f >= 14);
                logic exp_bit = (nrise < off) ? 1'b1 : word[31 - f];
                chk("R7/R8 output enable per slot", 32'(mdio_oe), 32'(exp_oe));
                if (exp_oe) chk("R5/R6 frame bit", 32'(mdio_o), 32'(exp_bit));
                if (nrise > 0) chk("R4 MDC period", 32'(cyc - t_last), 32'(2 * (div + 1)));
                t_last = cyc;
                nrise++;
            end
            prev_mdc = mdc;
            if (inject && nrise == 3 && !injected) begin
                bus_addr = 3'd4; bus_wdata = ~word; bus_wr = 1'b1; injected = 1;
            end
            begin
                int f2 = nrise - off;
                mdio_i = (isrd && f2 >= 16 && f2 <= 31) ? rdval[31 - f2] : 1'b1;
            end
            @(negedge clk);
        end
        chk("R5 MDC periods in frame", 32'(nrise), pre ? 32'd64 : 32'd32);
        chk("R9 busy clear delay", 32'(cyc - t_last), 32'(div + 1));
        chk("R9 MDC low after frame", 32'(mdc), 32'd0);
        chk("R9 OE low after frame", 32'(mdio_oe), 32'd0);
        if (isrd) begin
            bus_addr = 3'd4; #1;
            chk(inject ? "R10 read data after ignored write" : "R7 read data",
                32'(bus_rdata[15:0]), 32'(rdval));
            bus_addr = 3'd0;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1 reset state
        chk("R1 control after reset", bus_rdata, 32'h0);
        chk("R1 MDC after reset", 32'(mdc), 32'd0);
        chk("R1 OE after reset", 32'(mdio_oe), 32'd0);
        // R2 fields read back, busy bit not writable
        bus_addr = 3'd0; bus_wdata = 32'h0000_01FF; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0; #1;
        chk("R2 control readback", bus_rdata, 32'h0000_00FF);
        // R4 MDC idle low
        repeat (10) @(negedge clk);
        chk("R4 MDC low while idle", 32'(mdc), 32'd0);
        // vector table
        for (int i = 0; i < NV; i++) run_txn(V_WORD[i], V_PRE[i], V_DIV[i], V_RD[i], 1'b0);
        // R10 write while busy is ignored
        run_txn(mk(2'b10, 5'd3, 5'd4, 16'h0000), 1'b0, 1, 16'h5A5A, 1'b1);
        // R2 the typical start-up setting reads back
        @(negedge clk); bus_addr = 3'd0; bus_wdata = 32'h0000_009A; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0; #1;
        chk("R2 start-up divisor with preamble", bus_rdata, 32'h0000_009A);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule